// File: doc/BRIEF.md
# Per-Processor Interrupt Capture and Dispatch Unit

Every processor of a shared-memory multiprocessor receives the same set of interrupt conditions. This unit sits beside one processor's fetch logic and decides which of those conditions concern this processor. It records the accepted ones in an interrupt register and redirects instruction fetch when one of them is taken. A per-processor mask chooses which condition bits may be set at all. A condition that arrives while its mask bit is clear is dropped at once and never held.

When a recorded bit becomes eligible, the unit takes it. Among eligible bits, the one with the lowest index wins. Taking an interrupt clears that bit, saves the interrupted program counter, switches the processor into a privileged control mode and sends fetch to `VEC_BASE + 4*index`. In control mode only the most urgent conditions can preempt; the rest are recorded and wait. Power failure is always one of the urgent conditions.

A return strobe issued in control mode sends fetch back to the saved program counter and restores normal mode. Any deferred bits are then taken in turn. Loading the mask and returning are privileged. If either is attempted in normal mode, the unit raises the illegal-operation condition instead.

Top module: `irq_capture_unit`

## Requirements
- R1: After reset the interrupt register is all zero, the mask is all ones, the unit is in normal mode, the redirect strobe is low and the saved program counter is zero.
- R2: A condition input high at a clock edge sets its interrupt bit at that edge only if its mask bit is 1. A condition seen while its mask bit is 0 is discarded, and setting the mask bit later does not bring it back.
- R3: When several bits are eligible, the lowest-numbered one is taken. The redirect strobe is high for exactly one cycle, and the redirect address is `VEC_BASE + 4*index`. Condition index map: 0 power failure, 1 power restart, 2 memory or parity error, 3 illegal operation, 4 out-of-bounds write, 5 arithmetic overflow, 6 abnormal I/O end, 7 data absent, 8 I/O complete, 9 clock overflow, 10 processor-to-processor, 11 normal-mode halt, 12 and up the external request lines.
- R4: A take from normal mode saves `pc_i` from the take edge, clears the taken bit and sets `ctl_mode_o`. A condition latched at edge E is taken at edge E+1.
- R5: In control mode, bits with index of `HI_LEVELS` or more are recorded but not taken.
- R6: Bits with index below `HI_LEVELS` (always including power failure, index 0) are taken even in control mode. Such a nested take leaves the saved program counter unchanged.
- R7: `mask_wr_i` loads the mask from `mask_data_i` only in control mode. In normal mode the mask is left unchanged and interrupt bit 3 (illegal operation) is set, subject to its mask bit.
- R8: `rfc_i` in control mode pulses the redirect strobe with the saved program counter as address and returns to normal mode. Deferred bits are then taken starting on the next edge. `rfc_i` in normal mode redirects nothing and sets bit 3.
- R9: When a return and an eligible bit coincide at one edge, the return is performed and the bit stays pending until the following edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cond_i | input | N_SRC | Broadcast interrupt conditions, one bit per index |
| mask_wr_i | input | 1 | Mask load request (privileged) |
| mask_data_i | input | N_SRC | New mask value |
| rfc_i | input | 1 | Return-from-control request (privileged) |
| pc_i | input | PC_W | Program counter of the running instruction |
| redirect_o | output | 1 | One-cycle fetch redirect strobe |
| redirect_addr_o | output | PC_W | Fetch target for the redirect |
| saved_pc_o | output | PC_W | Program counter saved at the last take from normal mode |
| ctl_mode_o | output | 1 | High while in control mode |
| pending_o | output | N_SRC | Interrupt register contents |

## Verification
A condition shows in `pending_o` one edge after it is presented. It is taken, with the redirect, address, saved PC and mode updated together, one edge after that. A return shows its redirect and mode change one edge after `rfc_i`, and a deferred take follows one edge later. The bench drives inputs just after a rising edge and samples just after the next one. Each check therefore sits at the edge count stated here. Sweeps cover every index alone, every ordered pair for priority, every masked index, and the privileged-operation and collision cases.

// File: rtl/irq_unit_pkg.sv
// Package: condition index map and mode type shared by the interrupt unit.
// Assumes fixed conditions occupy the low indices; external lines follow.
package irq_unit_pkg;
    localparam int IDX_PWR_FAIL    = 0;
    localparam int IDX_PWR_RESTART = 1;
    localparam int IDX_MEM_ERR     = 2;
    localparam int IDX_ILLEGAL     = 3;
    localparam int IDX_BOUNDS      = 4;
    localparam int IDX_ARITH       = 5;
    localparam int IDX_IO_ABORT    = 6;
    localparam int IDX_DATA_ABSENT = 7;
    localparam int IDX_IO_DONE     = 8;
    localparam int IDX_RTC         = 9;
    localparam int IDX_XCPU        = 10;
    localparam int IDX_HALT        = 11;
    localparam int NUM_FIXED       = 12;

    typedef enum logic {
        MODE_NORMAL  = 1'b0,
        MODE_CONTROL = 1'b1
    } cpu_mode_e;
endpackage

// File: rtl/irq_latch.sv
// Module: mask register and interrupt register.
// A condition (or privilege fault) sets its bit only where the mask is 1;
// the bit being taken this edge is cleared before new sets are merged.
// Assumes take_clr_i is one-hot or zero.
module irq_latch #(
    parameter int N_SRC = 28
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [N_SRC-1:0] cond_i,
    input  logic             priv_fault_i,
    input  logic             mask_load_i,
    input  logic [N_SRC-1:0] mask_data_i,
    input  logic [N_SRC-1:0] take_clr_i,
    output logic [N_SRC-1:0] pending_o
);
    import irq_unit_pkg::*;

    logic [N_SRC-1:0] mask_q;
    logic [N_SRC-1:0] pend_q;
    logic [N_SRC-1:0] raw_set;
    logic [N_SRC-1:0] pend_d;

    // Merge external conditions with the internally raised illegal-op fault.
    always_comb begin
        raw_set = cond_i;
        raw_set[IDX_ILLEGAL] = cond_i[IDX_ILLEGAL] | priv_fault_i;
    end

    // Next interrupt register: drop the taken bit, add newly accepted bits.
    always_comb begin
        pend_d = (pend_q & ~take_clr_i) | (raw_set & mask_q);
    end

    // Mask register, loaded only when the privileged write is granted.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            mask_q <= '1;
        end else if (mask_load_i) begin
            mask_q <= mask_data_i;
        end
    end

    // Interrupt register state.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pend_q <= '0;
        end else begin
            pend_q <= pend_d;
        end
    end

    assign pending_o = pend_q;
endmodule

// File: rtl/irq_select.sv
// Module: eligibility filter and fixed-priority encoder.
// Indices below HI_LEVELS are eligible in any mode; the rest only in
// normal mode. The lowest eligible index wins. Purely combinational.
module irq_select #(
    parameter int N_SRC     = 28,
    parameter int HI_LEVELS = 1,
    parameter int IDX_W     = 5
) (
    input  logic [N_SRC-1:0] pending_i,
    input  logic             ctl_mode_i,
    output logic             any_o,
    output logic [IDX_W-1:0] idx_o
);
    logic [N_SRC-1:0] elig;

    // Per-bit eligibility class chosen at elaboration.
    for (genvar g = 0; g < N_SRC; g++) begin : g_elig
        if (g < HI_LEVELS) begin : g_hi
            assign elig[g] = pending_i[g];
        end else begin : g_lo
            assign elig[g] = pending_i[g] & ~ctl_mode_i;
        end
    end

    // Lowest-index search over eligible bits.
    always_comb begin
        idx_o = '0;
        for (int i = N_SRC - 1; i >= 0; i--) begin
            if (elig[i]) idx_o = IDX_W'(i);
        end
        any_o = |elig;
    end
endmodule

// File: rtl/irq_sequencer.sv
// Module: mode state, program-counter save and fetch redirect.
// A return in control mode wins over a take at the same edge. Saved PC
// is written only on a take from normal mode, so nested takes keep it.
module irq_sequencer #(
    parameter int N_SRC    = 28,
    parameter int PC_W     = 16,
    parameter int VEC_BASE = 'h100,
    parameter int IDX_W    = 5
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             any_i,
    input  logic [IDX_W-1:0] idx_i,
    input  logic [PC_W-1:0]  pc_i,
    input  logic             rfc_i,
    output logic             ctl_mode_o,
    output logic [N_SRC-1:0] take_clr_o,
    output logic             redirect_o,
    output logic [PC_W-1:0]  redirect_addr_o,
    output logic [PC_W-1:0]  saved_pc_o
);
    import irq_unit_pkg::*;

    localparam logic [PC_W-1:0] BASE_V = PC_W'(VEC_BASE);

    cpu_mode_e       mode_q;
    logic            do_ret;
    logic            do_take;
    logic [PC_W-1:0] vec_addr;

    // Decide between return and take for this edge.
    always_comb begin
        do_ret   = (mode_q == MODE_CONTROL) && rfc_i;
        do_take  = any_i && !do_ret;
        vec_addr = BASE_V + (PC_W'(idx_i) << 2);
    end

    // One-hot clear of the bit being taken.
    for (genvar g = 0; g < N_SRC; g++) begin : g_clr
        assign take_clr_o[g] = do_take && (idx_i == IDX_W'(g));
    end

    // Mode, saved PC and redirect registers.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            mode_q          <= MODE_NORMAL;
            redirect_o      <= 1'b0;
            redirect_addr_o <= '0;
            saved_pc_o      <= '0;
        end else begin
            redirect_o <= 1'b0;
            if (do_ret) begin
                mode_q          <= MODE_NORMAL;
                redirect_o      <= 1'b1;
                redirect_addr_o <= saved_pc_o;
            end else if (do_take) begin
                mode_q          <= MODE_CONTROL;
                redirect_o      <= 1'b1;
                redirect_addr_o <= vec_addr;
                if (mode_q == MODE_NORMAL) saved_pc_o <= pc_i;
            end
        end
    end

    assign ctl_mode_o = (mode_q == MODE_CONTROL);
endmodule

// File: rtl/irq_capture_unit.sv
// Module: top of the per-processor interrupt unit. Wires the latch,
// selector and sequencer, and turns privileged requests made in normal
// mode into an illegal-operation condition.
module irq_capture_unit #(
    parameter int N_EXT     = 16,
    parameter int PC_W      = 16,
    parameter int VEC_BASE  = 'h100,
    parameter int HI_LEVELS = 1,
    localparam int N_SRC    = irq_unit_pkg::NUM_FIXED + N_EXT,
    localparam int IDX_W    = $clog2(N_SRC)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [N_SRC-1:0] cond_i,
    input  logic             mask_wr_i,
    input  logic [N_SRC-1:0] mask_data_i,
    input  logic             rfc_i,
    input  logic [PC_W-1:0]  pc_i,
    output logic             redirect_o,
    output logic [PC_W-1:0]  redirect_addr_o,
    output logic [PC_W-1:0]  saved_pc_o,
    output logic             ctl_mode_o,
    output logic [N_SRC-1:0] pending_o
);
    logic             priv_fault;
    logic             mask_load;
    logic [N_SRC-1:0] take_clr;
    logic             any_elig;
    logic [IDX_W-1:0] sel_idx;

    // Privilege gate on mask load and return.
    always_comb begin
        mask_load  = mask_wr_i & ctl_mode_o;
        priv_fault = ~ctl_mode_o & (mask_wr_i | rfc_i);
    end

    irq_latch #(.N_SRC(N_SRC)) u_latch (
        .clk         (clk),
        .rst_n       (rst_n),
        .cond_i      (cond_i),
        .priv_fault_i(priv_fault),
        .mask_load_i (mask_load),
        .mask_data_i (mask_data_i),
        .take_clr_i  (take_clr),
        .pending_o   (pending_o)
    );

    irq_select #(.N_SRC(N_SRC), .HI_LEVELS(HI_LEVELS), .IDX_W(IDX_W)) u_select (
        .pending_i (pending_o),
        .ctl_mode_i(ctl_mode_o),
        .any_o     (any_elig),
        .idx_o     (sel_idx)
    );

    irq_sequencer #(.N_SRC(N_SRC), .PC_W(PC_W), .VEC_BASE(VEC_BASE), .IDX_W(IDX_W)) u_seq (
        .clk            (clk),
        .rst_n          (rst_n),
        .any_i          (any_elig),
        .idx_i          (sel_idx),
        .pc_i           (pc_i),
        .rfc_i          (rfc_i),
        .ctl_mode_o     (ctl_mode_o),
        .take_clr_o     (take_clr),
        .redirect_o     (redirect_o),
        .redirect_addr_o(redirect_addr_o),
        .saved_pc_o     (saved_pc_o)
    );
endmodule

// File: rtl/irq_capture_unit_chk.sv
// Checker: temporal properties over the unit's ports, bound to the top.
module irq_capture_unit_chk #(
    parameter int N_SRC     = 28,
    parameter int PC_W      = 16,
    parameter int VEC_BASE  = 'h100,
    parameter int HI_LEVELS = 1
) (
    input logic             clk,
    input logic             rst_n,
    input logic [N_SRC-1:0] cond_i,
    input logic             rfc_i,
    input logic [PC_W-1:0]  pc_i,
    input logic             redirect_o,
    input logic [PC_W-1:0]  redirect_addr_o,
    input logic [PC_W-1:0]  saved_pc_o,
    input logic             ctl_mode_o,
    input logic [N_SRC-1:0] pending_o
);
    localparam logic [N_SRC-1:0] HI_MASK = {N_SRC{1'b1}} >> (N_SRC - HI_LEVELS);
    localparam logic [PC_W-1:0]  BASE_V  = PC_W'(VEC_BASE);

    // R4
    enter_saves_pc_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(ctl_mode_o) |-> (redirect_o && saved_pc_o == $past(pc_i)));

    // R5
    low_deferred_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (ctl_mode_o && !rfc_i && (pending_o & HI_MASK) == '0) |=> !redirect_o);

    // R6
    pwr_preempt_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (pending_o[0] && !(ctl_mode_o && rfc_i)) |=> (redirect_o && redirect_addr_o == BASE_V));

    // R8
    return_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (ctl_mode_o && rfc_i) |=> (!ctl_mode_o && redirect_o && redirect_addr_o == saved_pc_o));

    // R3
    redirect_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
        redirect_o |-> ($past(|pending_o) || $past(ctl_mode_o && rfc_i)));

    // R2
    no_spurious_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(cond_i) == '0 && !$past(rfc_i) && $past(pending_o) == '0) |-> (pending_o[N_SRC-1:4] == '0));
endmodule

bind irq_capture_unit irq_capture_unit_chk #(
    .N_SRC(N_SRC), .PC_W(PC_W), .VEC_BASE(VEC_BASE), .HI_LEVELS(HI_LEVELS)
) u_chk (
    .clk            (clk),
    .rst_n          (rst_n),
    .cond_i         (cond_i),
    .rfc_i          (rfc_i),
    .pc_i           (pc_i),
    .redirect_o     (redirect_o),
    .redirect_addr_o(redirect_addr_o),
    .saved_pc_o     (saved_pc_o),
    .ctl_mode_o     (ctl_mode_o),
    .pending_o      (pending_o)
);

// File: tb/tb_irq_capture_unit.sv
module tb_irq_capture_unit;
    localparam int CLK_PERIOD = 10;
    localparam int N_EXT = 4;
    localparam int N     = 12 + N_EXT;
    localparam int PW    = 16;
    localparam int BASE  = 'h100;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic [N-1:0]  cond_i = '0;
    logic          mask_wr_i = 1'b0;
    logic [N-1:0]  mask_data_i = '0;
    logic          rfc_i = 1'b0;
    logic [PW-1:0] pc_i = '0;
    logic          redirect_o;
    logic [PW-1:0] redirect_addr_o;
    logic [PW-1:0] saved_pc_o;
    logic          ctl_mode_o;
    logic [N-1:0]  pending_o;

    int n_checks = 0;
    int n_fail = 0;
    bit done = 1'b0;

    irq_capture_unit #(.N_EXT(N_EXT), .PC_W(PW), .VEC_BASE(BASE), .HI_LEVELS(1)) dut (
        .clk(clk), .rst_n(rst_n), .cond_i(cond_i), .mask_wr_i(mask_wr_i),
        .mask_data_i(mask_data_i), .rfc_i(rfc_i), .pc_i(pc_i),
        .redirect_o(redirect_o), .redirect_addr_o(redirect_addr_o),
        .saved_pc_o(saved_pc_o), .ctl_mode_o(ctl_mode_o), .pending_o(pending_o)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    task automatic tick();
        @(posedge clk);
        #1;
    endtask

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    function automatic logic [PW-1:0] vec(input int idx);
        return PW'(BASE + 4 * idx);
    endfunction

    task automatic finish_run();
        if (!done) begin
            done = 1'b1;
            $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
            $finish;
        end
    endtask

    // Enter control mode through condition idx, pc p.
    task automatic enter_ctl(input int idx, input logic [PW-1:0] p);
        pc_i = p; cond_i = N'(1) << idx; tick(); cond_i = '0; tick();
    endtask

    task automatic do_return();
        rfc_i = 1'b1; tick(); rfc_i = 1'b0;
    endtask

    initial begin
        #(CLK_PERIOD * 150000);
        n_checks++; n_fail++;
        $display("FAIL watchdog actual=running expected=finished");
        finish_run();
    end

    initial begin
        tick(); tick(); tick();
        rst_n = 1'b1;
        // R1 reset state
        chk("R1 pending", 32'(pending_o), 0);
        chk("R1 redirect", 32'(redirect_o), 0);
        chk("R1 ctl", 32'(ctl_mode_o), 0);
        chk("R1 saved", 32'(saved_pc_o), 0);

        // Every index alone: latch, take, return.
        for (int i = 0; i < N; i++) begin
            logic [PW-1:0] p;
            p = PW'(16'h1000 + i * 16);
            pc_i = p; cond_i = N'(1) << i; tick(); cond_i = '0;
            chk("R2 latched", 32'(pending_o), 32'(N'(1) << i));
            chk("R4 not yet", 32'(redirect_o), 0);
            tick();
            chk("R3 redirect", 32'(redirect_o), 1);
            chk("R3 vector", 32'(redirect_addr_o), 32'(vec(i)));
            chk("R4 ctl", 32'(ctl_mode_o), 1);
            chk("R4 saved", 32'(saved_pc_o), 32'(p));
            chk("R4 cleared", 32'(pending_o), 0);
            tick();
            chk("R3 pulse", 32'(redirect_o), 0);
            do_return();
            chk("R8 redirect", 32'(redirect_o), 1);
            chk("R8 addr", 32'(redirect_addr_o), 32'(p));
            chk("R8 normal", 32'(ctl_mode_o), 0);
            tick();
        end

        // Every ordered pair: lower index first, the other deferred.
        for (int i = 0; i < N; i++) begin
            for (int j = i + 1; j < N; j++) begin
                pc_i = 16'h4000; cond_i = (N'(1) << i) | (N'(1) << j); tick(); cond_i = '0; tick();
                chk("R3 pair vector", 32'(redirect_addr_o), 32'(vec(i)));
                chk("R5 pair deferred", 32'(pending_o), 32'(N'(1) << j));
                do_return();
                chk("R8 pair return", 32'(ctl_mode_o), 0);
                pc_i = 16'h4444; tick();
                chk("R8 deferred taken", 32'(redirect_addr_o), 32'(vec(j)));
                chk("R8 deferred saved", 32'(saved_pc_o), 32'h4444);
                do_return(); tick();
            end
        end

        // Control mode: low bits recorded only, power fail preempts.
        enter_ctl(12, 16'h5000);
        for (int k = 1; k < N; k++) begin
            cond_i = N'(1) << k; tick(); cond_i = '0; tick();
            chk("R5 no take", 32'(redirect_o), 0);
            chk("R5 still ctl", 32'(ctl_mode_o), 1);
        end
        chk("R5 recorded", 32'(pending_o), 32'({N{1'b1}} & ~N'(1)));
        pc_i = 16'h5555; cond_i = N'(1); tick(); cond_i = '0; tick();
        chk("R6 preempt", 32'(redirect_o), 1);
        chk("R6 vector", 32'(redirect_addr_o), 32'(vec(0)));
        chk("R6 saved kept", 32'(saved_pc_o), 32'h5000);
        do_return();
        chk("R8 back", 32'(redirect_addr_o), 32'h5000);
        pc_i = 16'h6000; tick();
        chk("R8 first deferred", 32'(redirect_addr_o), 32'(vec(1)));
        for (int k = 2; k < N; k++) begin
            do_return(); tick();
            chk("R8 drain", 32'(redirect_addr_o), 32'(vec(k)));
        end
        do_return(); tick();
        chk("R8 drained", 32'(pending_o), 0);

        // Masked index is dropped and not revived.
        for (int k = 1; k < N; k++) begin
            enter_ctl(0, 16'h7000);
            mask_wr_i = 1'b1; mask_data_i = ~(N'(1) << k); tick(); mask_wr_i = 1'b0;
            do_return(); tick();
            cond_i = N'(1) << k; tick(); cond_i = '0;
            chk("R2 dropped", 32'(pending_o), 0);
            tick();
            chk("R2 no redirect", 32'(redirect_o), 0);
            enter_ctl(0, 16'h7000);
            mask_wr_i = 1'b1; mask_data_i = '1; tick(); mask_wr_i = 1'b0;
            do_return(); tick();
            chk("R2 not revived", 32'(pending_o), 0);
            chk("R2 idle", 32'(redirect_o), 0);
        end

        // Mask write from normal mode.
        mask_wr_i = 1'b1; mask_data_i = '0; tick(); mask_wr_i = 1'b0;
        chk("R7 illegal set", 32'(pending_o), 32'h8);
        tick();
        chk("R7 illegal taken", 32'(redirect_addr_o), 32'(vec(3)));
        do_return(); tick();
        cond_i = N'(1) << 5; tick(); cond_i = '0;
        chk("R7 mask unchanged", 32'(pending_o), 32'h20);
        tick(); do_return(); tick();

        // Return from normal mode.
        rfc_i = 1'b1; tick(); rfc_i = 1'b0;
        chk("R8 normal rfc illegal", 32'(pending_o), 32'h8);
        chk("R8 normal rfc no redirect", 32'(redirect_o), 0);
        tick();
        chk("R8 illegal vector", 32'(redirect_addr_o), 32'(vec(3)));
        do_return(); tick();

        // Return and take at one edge.
        enter_ctl(12, 16'h2222);
        cond_i = N'(1); tick(); cond_i = '0;
        rfc_i = 1'b1; tick(); rfc_i = 1'b0;
        chk("R9 return wins", 32'(redirect_addr_o), 32'h2222);
        chk("R9 normal", 32'(ctl_mode_o), 0);
        chk("R9 still pending", 32'(pending_o), 1);
        pc_i = 16'h3333; tick();
        chk("R9 then take", 32'(redirect_addr_o), 32'(vec(0)));
        chk("R9 saved", 32'(saved_pc_o), 32'h3333);
        do_return(); tick();

        finish_run();
    end
endmodule